// File: doc/BRIEF.md
# Strobed Shared-Bus Register Slave

This block is the register slave for a pin-electronics controller whose host reaches it over one 10-bit bus that carries first an address and then data. Three level strobes, for address, write and read, mark the phases, and an active-low chip select qualifies all of them. Each strobe is sampled on the core clock and acts on its rising edge. The address phase loads an internal address register. The write phase stores the bus into the register that address selects. During a read phase the slave drives the selected register onto the bus for as long as the read strobe is high, and the host releases the bus for that time.

The low part of the address space is a per-channel register file: 16 channels, each with three timing blocks of eight registers. Above it sits a small global block whose read map and write map differ. The write side holds the loop and end addresses, a memory control register, a memory index and four staging words. The read side returns status and address words from the sequencer and four result words. Four small memory banks are reached indirectly. The host loads an index and the staging words, then writes the control register twice: first with only the access bit set, then with access plus one select bit. Bank 3 is slow and finishes several clocks after the start; the other banks finish on the next clock.

Top module: `strobe_regbus`

## Requirements
- R1: While csN is low, the first clock edge that samples adrStb high after a cycle with it low (or with csN high) loads busIn into the address register.
- R2: The first clock edge that samples wrStb high with csN low stores busIn into the addressed register. Addresses 0x000 to 0x17F form the per-channel file, located at channel*24 + timing*8 + offset (timing 0, 1 or 2; channels 0 to 15). The mode register sits at offset 7 and the format register at offset 15 of the channel's block. Every location reads back what was last written to it.
- R3: busOe is high, and busOut carries the selected register, exactly while rdStb is high and csN is low. At all other times busOe is low and busOut is zero.
- R4: While csN is high, the address and write strobes have no effect and the bus is not driven.
- R5: Write map: 0x180 loop address (loopAddr), 0x181 end address (endAddr), 0x182 memory index, 0x183 memory control, 0x184 to 0x187 staging words 0 to 3, 0x188 DRAM control (dramCtl). Bit 9 of memory control drives vramBypass.
- R6: Read map: 0x180 statusIn, 0x181 vecAddrIn, 0x182 holdAddrIn, 0x183 cmdIn, 0x184 to 0x187 result words 0 to 3. Reads from 0x188 up to 0x3FF return zero, and writes to 0x189 and above change nothing.
- R7: Reset clears every register, every bank entry and every result word to zero. It also drives loopAddr, endAddr, dramCtl and vramBypass low.
- R8: In memory control, bit 8 is the access bit, bits 0 to 3 request a write to banks 0 to 3, and bits 4 to 7 request a read of banks 0 to 3. A bank access starts only on a control write that sets bit 8 with at least one select bit, and only when the control register held bit 8 with all select bits clear. If several select bits are set, the lowest-numbered one wins. A write copies the staging words into the bank entry given by the low 4 bits of the memory index. A read copies that entry into the result words.
- R9: A bank 3 access completes 6 clocks after the clock edge of the starting control write. Any other bank completes 1 clock after it. The result words keep their old value until completion.
- R10: A start that arrives while an access is still pending, including the clock on which that access completes, is dropped. A control write that sets a select bit without the access-only step before it starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low, qualifies all strobes |
| adrStb | input | 1 | Address strobe |
| wrStb | input | 1 | Write strobe |
| rdStb | input | 1 | Read strobe |
| busIn | input | 10 | Bus value seen from the pad |
| busOut | output | 10 | Value the slave drives during a read |
| busOe | output | 1 | Pad driver enable for busOut |
| statusIn | input | 10 | Sequencer status word, readable at 0x180 |
| vecAddrIn | input | 10 | Current vector address, readable at 0x181 |
| holdAddrIn | input | 10 | Holding memory address, readable at 0x182 |
| cmdIn | input | 10 | Current command word, readable at 0x183 |
| loopAddr | output | 10 | Loop address register |
| endAddr | output | 10 | End address register |
| dramCtl | output | 10 | DRAM control register |
| vramBypass | output | 1 | Bit 9 of memory control |

## Verification
The bench aims at the places where the two register maps overlap. A slave that shares read and write storage would return the loop address instead of statusIn at 0x180. One that decodes the block end loosely would echo data at 0x188 or 0x189. A handshake shortcut would let a lone select write, or a start landing on the completion clock of a bank 3 access, change a bank, and that shows up later as a wrong readback. The result words are read a few clocks after a slow start and again after the window has passed, so a sequencer that finishes bank 3 early, or finishes the fast banks late, returns the wrong word. Chip-select gating and the channel address arithmetic are checked through readback at the mode and format offsets and at the last channel location.

// File: rtl/srb_pkg.sv
package srb_pkg;
  // strobes the control half hands to the datapath, one cycle wide except driveBus
  typedef struct packed {
    logic latchAddr;
    logic writeReg;
    logic driveBus;
  } strobeSet_t;
endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       adrStb,
  input  logic       wrStb,
  input  logic       rdStb,
  output strobeSet_t stb
);
  logic adrGated, wrGated;
  logic adrPrev, wrPrev;

  assign adrGated = adrStb & ~csN;
  assign wrGated  = wrStb & ~csN;

  always_ff @(posedge clk) begin
    if (rst) begin
      adrPrev <= 1'b0;
      wrPrev  <= 1'b0;
    end else begin
      adrPrev <= adrGated;
      wrPrev  <= wrGated;
    end
  end

  always_comb begin
    stb.latchAddr = adrGated & ~adrPrev;
    stb.writeReg  = wrGated & ~wrPrev;
    stb.driveBus  = rdStb & ~csN;
  end
endmodule

// File: rtl/srb_dp.sv
module srb_dp
  import srb_pkg::*;
#(
  parameter int BUS_W       = 10,
  parameter int NUM_CHAN    = 16,
  parameter int CHAN_STRIDE = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobeSet_t             stb,
  input  logic [BUS_W-1:0]       busIn,
  input  logic [BUS_W-1:0]       statusIn,
  input  logic [BUS_W-1:0]       vecAddrIn,
  input  logic [BUS_W-1:0]       holdAddrIn,
  input  logic [BUS_W-1:0]       cmdIn,
  input  logic [3:0][BUS_W-1:0]  rdWords,
  output logic [BUS_W-1:0]       busOut,
  output logic                   busOe,
  output logic [BUS_W-1:0]       addrQ,
  output logic [BUS_W-1:0]       loopAddr,
  output logic [BUS_W-1:0]       endAddr,
  output logic [BUS_W-1:0]       dramCtl,
  output logic [BUS_W-1:0]       memIdx,
  output logic                   vramBypass,
  output logic                   memStart,
  output logic [7:0]             memSel,
  output logic [3:0][BUS_W-1:0]  wdWords
);
  localparam int CHAN_SPACE  = NUM_CHAN * CHAN_STRIDE;
  localparam int CW          = $clog2(CHAN_SPACE);
  localparam int GLOBAL_SPAN = 9;
  localparam logic [BUS_W-1:0] GBASE = BUS_W'(CHAN_SPACE);

  logic [BUS_W-1:0] chanRegs [CHAN_SPACE];
  logic [BUS_W-1:0] ramCtl, gDelta, rdVal;
  logic             inChan, inGlobal;
  logic [3:0]       gOff;

  assign inChan   = addrQ < GBASE;
  assign gDelta   = addrQ - GBASE;
  assign inGlobal = !inChan && (gDelta < BUS_W'(GLOBAL_SPAN));
  assign gOff     = gDelta[3:0];

  // two-step handshake: previous control value must be access-only
  assign memStart = stb.writeReg && inGlobal && (gOff == 4'd3) &&
                    busIn[8] && (busIn[7:0] != 8'd0) &&
                    ramCtl[8] && (ramCtl[7:0] == 8'd0);
  assign memSel     = busIn[7:0];
  assign vramBypass = ramCtl[9];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      loopAddr <= '0;
      endAddr  <= '0;
      dramCtl  <= '0;
      memIdx   <= '0;
      ramCtl   <= '0;
      wdWords  <= '0;
      for (int i = 0; i < CHAN_SPACE; i++) chanRegs[i] <= '0;
    end else begin
      if (stb.latchAddr) addrQ <= busIn;
      if (stb.writeReg) begin
        if (inChan) begin
          chanRegs[addrQ[CW-1:0]] <= busIn;
        end else if (inGlobal) begin
          case (gOff)
            4'd0:    loopAddr <= busIn;
            4'd1:    endAddr  <= busIn;
            4'd2:    memIdx   <= busIn;
            4'd3:    ramCtl   <= busIn;
            4'd8:    dramCtl  <= busIn;
            default: wdWords[gOff[1:0]] <= busIn;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdVal = '0;
    if (inChan) begin
      rdVal = chanRegs[addrQ[CW-1:0]];
    end else if (inGlobal && !gOff[3]) begin
      case (gOff[2:0])
        3'd0:    rdVal = statusIn;
        3'd1:    rdVal = vecAddrIn;
        3'd2:    rdVal = holdAddrIn;
        3'd3:    rdVal = cmdIn;
        default: rdVal = rdWords[gOff[1:0]];
      endcase
    end
  end

  assign busOe  = stb.driveBus;
  assign busOut = stb.driveBus ? rdVal : '0;
endmodule

// File: rtl/srb_memseq.sv
module srb_memseq #(
  parameter int BUS_W     = 10,
  parameter int MEM_DEPTH = 16,
  parameter int VRAM_LAT  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [7:0]            sel,
  input  logic [BUS_W-1:0]      idx,
  input  logic [3:0][BUS_W-1:0] wd,
  output logic [3:0][BUS_W-1:0] rdWords,
  output logic                  busy
);
  localparam int NUM_BANKS = 4;
  localparam int SLOW_BANK = 3;
  localparam int IW        = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam int CNTW      = $clog2(VRAM_LAT + 1);

  logic [2:0]            pick;
  logic [1:0]            opBank;
  logic                  opRead;
  logic [IW-1:0]         opIdx;
  logic [3:0][BUS_W-1:0] opData;
  logic [CNTW-1:0]       cnt;
  logic                  doOp;
  logic [3:0][BUS_W-1:0] bankRd [NUM_BANKS];

  // lowest set select bit wins
  always_comb begin
    pick = 3'd0;
    for (int i = 7; i >= 0; i--) if (sel[i]) pick = 3'(i);
  end

  assign doOp = busy && (cnt == '0);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [3:0][BUS_W-1:0] store [MEM_DEPTH];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < MEM_DEPTH; j++) store[j] <= '0;
      end else if (doOp && !opRead && (opBank == 2'(g))) begin
        store[opIdx] <= opData;
      end
    end
    assign bankRd[g] = store[opIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      opBank  <= '0;
      opRead  <= 1'b0;
      opIdx   <= '0;
      opData  <= '0;
      rdWords <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        opBank <= pick[1:0];
        opRead <= pick[2];
        opIdx  <= idx[IW-1:0];
        opData <= wd;
        cnt    <= (pick[1:0] == 2'(SLOW_BANK)) ? CNTW'(VRAM_LAT - 1) : '0;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
      if (opRead) rdWords <= bankRd[opBank];
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/strobe_regbus.sv
module strobe_regbus
  import srb_pkg::*;
#(
  parameter int BUS_W       = 10,
  parameter int NUM_CHAN    = 16,
  parameter int CHAN_STRIDE = 24,
  parameter int MEM_DEPTH   = 16,
  parameter int VRAM_LAT    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             adrStb,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  input  logic [BUS_W-1:0] statusIn,
  input  logic [BUS_W-1:0] vecAddrIn,
  input  logic [BUS_W-1:0] holdAddrIn,
  input  logic [BUS_W-1:0] cmdIn,
  output logic [BUS_W-1:0] loopAddr,
  output logic [BUS_W-1:0] endAddr,
  output logic [BUS_W-1:0] dramCtl,
  output logic             vramBypass
);
  strobeSet_t            stb;
  logic [BUS_W-1:0]      addrQ, memIdx;
  logic                  memStart, memBusy;
  logic [7:0]            memSel;
  logic [3:0][BUS_W-1:0] wdWords, rdWords;

  srb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(csN),
    .adrStb(adrStb), .wrStb(wrStb), .rdStb(rdStb), .stb(stb)
  );

  srb_dp #(.BUS_W(BUS_W), .NUM_CHAN(NUM_CHAN), .CHAN_STRIDE(CHAN_STRIDE)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .busIn(busIn),
    .statusIn(statusIn), .vecAddrIn(vecAddrIn), .holdAddrIn(holdAddrIn), .cmdIn(cmdIn),
    .rdWords(rdWords), .busOut(busOut), .busOe(busOe), .addrQ(addrQ),
    .loopAddr(loopAddr), .endAddr(endAddr), .dramCtl(dramCtl), .memIdx(memIdx),
    .vramBypass(vramBypass), .memStart(memStart), .memSel(memSel), .wdWords(wdWords)
  );

  srb_memseq #(.BUS_W(BUS_W), .MEM_DEPTH(MEM_DEPTH), .VRAM_LAT(VRAM_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(memStart), .sel(memSel), .idx(memIdx),
    .wd(wdWords), .rdWords(rdWords), .busy(memBusy)
  );
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
  parameter int BUS_W       = 10,
  parameter int NUM_CHAN    = 16,
  parameter int CHAN_STRIDE = 24,
  parameter int VRAM_LAT    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             csN,
  input logic             adrStb,
  input logic             rdStb,
  input logic [BUS_W-1:0] busIn,
  input logic [BUS_W-1:0] busOut,
  input logic             busOe,
  input logic [BUS_W-1:0] addrQ,
  input logic             memBusy
);
  localparam logic [BUS_W-1:0] UNDEC_BASE = BUS_W'(NUM_CHAN * CHAN_STRIDE + 8);
  localparam int RW = $clog2(VRAM_LAT + 2) + 1;

  logic [RW-1:0] busyRun;
  always_ff @(posedge clk) begin
    if (rst) busyRun <= '0;
    else if (!memBusy) busyRun <= '0;
    else if (busyRun != '1) busyRun <= busyRun + 1'b1;
  end

  p_addr_latch_r1: assert property (@(posedge clk) disable iff (rst)
    (adrStb && !csN && !$past(adrStb && !csN)) |=> (addrQ == $past(busIn)));

  p_no_idle_drive_r3: assert property (@(posedge clk) disable iff (rst)
    (!rdStb || csN) |-> (!busOe && busOut == '0));

  p_cs_blocks_addr_r4: assert property (@(posedge clk) disable iff (rst)
    csN |=> $stable(addrQ));

  p_undecoded_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (busOe && addrQ >= UNDEC_BASE) |-> (busOut == '0));

  p_slow_window_r9: assert property (@(posedge clk) disable iff (rst)
    busyRun <= RW'(VRAM_LAT));
endmodule

bind strobe_regbus srb_checker #(
  .BUS_W(BUS_W), .NUM_CHAN(NUM_CHAN), .CHAN_STRIDE(CHAN_STRIDE), .VRAM_LAT(VRAM_LAT)
) u_chk (
  .clk(clk), .rst(rst), .csN(csN), .adrStb(adrStb), .rdStb(rdStb),
  .busIn(busIn), .busOut(busOut), .busOe(busOe), .addrQ(addrQ), .memBusy(memBusy)
);

// File: tb/strobe_regbus_bench.sv
module strobe_regbus_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CHAN_SPACE = 384;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b0;
  logic       adrStb = 1'b0, wrStb = 1'b0, rdStb = 1'b0;
  logic [9:0] busIn = '0;
  logic [9:0] busOut;
  logic       busOe;
  logic [9:0] statusIn = '0, vecAddrIn = '0, holdAddrIn = '0, cmdIn = '0;
  logic [9:0] loopAddr, endAddr, dramCtl;
  logic       vramBypass;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cycles  = 0;
  bit  doneFlag = 0;

  logic [9:0] chanM [CHAN_SPACE];
  logic [3:0][9:0] memM [4][16];
  logic [3:0][9:0] rdM;

  strobe_regbus u_strobe_regbus (
    .clk(clk), .rst(rst), .csN(csN), .adrStb(adrStb), .wrStb(wrStb), .rdStb(rdStb),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .statusIn(statusIn), .vecAddrIn(vecAddrIn), .holdAddrIn(holdAddrIn), .cmdIn(cmdIn),
    .loopAddr(loopAddr), .endAddr(endAddr), .dramCtl(dramCtl), .vramBypass(vramBypass)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] chanAddr(input int ch, input int tsel, input int off);
    return 10'(ch * 24 + tsel * 8 + off);
  endfunction

  task automatic busWrite(input logic [9:0] a, input logic [9:0] d);
    @(negedge clk); busIn = a; adrStb = 1'b1;
    @(negedge clk); adrStb = 1'b0; busIn = d; wrStb = 1'b1;
    @(negedge clk); wrStb = 1'b0; busIn = '0;
  endtask

  task automatic readNoAddr(output logic [9:0] v, output logic oe);
    @(negedge clk); rdStb = 1'b1;
    #1; v = busOut; oe = busOe;
    @(negedge clk); rdStb = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [9:0] v);
    logic oe;
    @(negedge clk); busIn = a; adrStb = 1'b1;
    @(negedge clk); adrStb = 1'b0; busIn = '0; rdStb = 1'b1;
    #1; v = busOut; oe = busOe;
    @(negedge clk); rdStb = 1'b0;
    if (!csN) chk("R3 drive during read", {9'd0, oe}, 10'd1);
    #1; chk("R3 released after read", {9'd0, busOe}, 10'd0);
  endtask

  task automatic rdChk(input string req, input logic [9:0] a, input logic [9:0] exp);
    logic [9:0] v;
    busRead(a, v);
    chk(req, v, exp);
  endtask

  task automatic ramWrite(input int b, input logic [9:0] idx, input logic [3:0][9:0] w);
    busWrite(10'h182, idx);
    for (int i = 0; i < 4; i++) busWrite(10'(10'h184 + i), w[i]);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'(10'h100 | (1 << b)));
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h000);
    memM[b][idx[3:0]] = w;
  endtask

  task automatic ramReadChk(input string req, input int b, input logic [9:0] idx);
    busWrite(10'h182, idx);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'(10'h100 | (16 << b)));
    repeat (8) @(negedge clk);
    rdM = memM[b][idx[3:0]];
    for (int i = 0; i < 4; i++) rdChk(req, 10'(10'h184 + i), rdM[i]);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h000);
  endtask

  task automatic clearModels();
    for (int i = 0; i < CHAN_SPACE; i++) chanM[i] = '0;
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 16; j++) memM[b][j] = '0;
    rdM = '0;
  endtask

  initial begin
    logic [9:0] v, a, d;
    logic oe;
    logic [3:0][9:0] w;
    void'($urandom(32'd4711));
    clearModels();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7 reset state
    chk("R7 loopAddr reset", loopAddr, 10'd0);
    chk("R7 endAddr reset", endAddr, 10'd0);
    chk("R7 dramCtl reset", dramCtl, 10'd0);
    chk("R7 vramBypass reset", {9'd0, vramBypass}, 10'd0);
    chk("R3 idle no drive", {9'd0, busOe}, 10'd0);
    rdChk("R7 channel reg reset", 10'h000, 10'd0);
    rdChk("R7 result word reset", 10'h184, 10'd0);

    // R2 directed channel addressing
    a = chanAddr(5, 2, 6); busWrite(a, 10'h2A5); chanM[a] = 10'h2A5;
    a = chanAddr(3, 0, 7); busWrite(a, 10'h13C); chanM[a] = 10'h13C;
    a = chanAddr(15, 0, 15); busWrite(a, 10'h0F1); chanM[a] = 10'h0F1;
    a = 10'h17F; busWrite(a, 10'h3FF); chanM[a] = 10'h3FF;
    rdChk("R2 delay block offset", chanAddr(5, 2, 6), 10'h2A5);
    rdChk("R2 mode register", chanAddr(3, 0, 7), 10'h13C);
    rdChk("R2 format register", chanAddr(15, 0, 15), 10'h0F1);
    rdChk("R2 last channel location", 10'h17F, 10'h3FF);
    rdChk("R2 neighbour untouched", chanAddr(5, 2, 5), 10'h000);

    // R1 R2 random channel traffic
    for (int n = 0; n < 40; n++) begin
      a = 10'($urandom_range(0, CHAN_SPACE - 1));
      d = 10'($urandom);
      busWrite(a, d);
      chanM[a] = d;
    end
    for (int n = 0; n < 40; n++) begin
      a = 10'($urandom_range(0, CHAN_SPACE - 1));
      rdChk("R1 R2 random readback", a, chanM[a]);
    end

    // R5 R6 global maps
    statusIn = 10'h155; vecAddrIn = 10'h0AB; holdAddrIn = 10'h321; cmdIn = 10'h2C4;
    busWrite(10'h180, 10'h07E);
    busWrite(10'h181, 10'h1E1);
    busWrite(10'h188, 10'h222);
    busWrite(10'h183, 10'h200);
    @(negedge clk);
    chk("R5 loopAddr", loopAddr, 10'h07E);
    chk("R5 endAddr", endAddr, 10'h1E1);
    chk("R5 dramCtl", dramCtl, 10'h222);
    chk("R5 vramBypass", {9'd0, vramBypass}, 10'd1);
    rdChk("R6 status at 0x180", 10'h180, 10'h155);
    rdChk("R6 vector addr at 0x181", 10'h181, 10'h0AB);
    rdChk("R6 holding addr at 0x182", 10'h182, 10'h321);
    rdChk("R6 command at 0x183", 10'h183, 10'h2C4);
    rdChk("R6 0x188 reads zero", 10'h188, 10'h000);
    busWrite(10'h189, 10'h3AA);
    rdChk("R6 0x189 reads zero", 10'h189, 10'h000);
    busWrite(10'h3FF, 10'h155);
    rdChk("R6 top address reads zero", 10'h3FF, 10'h000);
    chk("R6 loopAddr unchanged by undecoded write", loopAddr, 10'h07E);
    chk("R6 dramCtl unchanged by undecoded write", dramCtl, 10'h222);
    busWrite(10'h183, 10'h000);
    @(negedge clk);
    chk("R5 vramBypass cleared", {9'd0, vramBypass}, 10'd0);

    // R4 chip select gating
    busWrite(10'h005, 10'h111); chanM[5] = 10'h111;
    csN = 1'b1;
    busWrite(10'h006, 10'h333);
    busWrite(10'h005, 10'h2DD);
    readNoAddr(v, oe);
    chk("R4 no drive while deselected", {9'd0, oe}, 10'd0);
    csN = 1'b0;
    readNoAddr(v, oe);
    chk("R4 address kept while deselected", v, 10'h111);
    rdChk("R4 write ignored while deselected", 10'h006, chanM[6]);

    // R8 each bank write then read
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 4; i++) w[i] = 10'($urandom);
      a = 10'($urandom_range(0, 15));
      ramWrite(b, a, w);
      ramReadChk("R8 bank readback", b, a);
    end
    for (int i = 0; i < 4; i++) w[i] = 10'(10'h040 + i);
    ramWrite(2, 10'h013, w);
    ramReadChk("R8 index uses low four bits", 2, 10'h003);

    // R10 select without access-only step
    for (int i = 0; i < 4; i++) busWrite(10'(10'h184 + i), 10'h3C3);
    busWrite(10'h182, 10'h007);
    busWrite(10'h183, 10'h101);
    busWrite(10'h183, 10'h000);
    ramReadChk("R10 skipped handshake ignored", 0, 10'h007);

    // R8 lowest select bit wins (bank 1 over bank 2)
    for (int i = 0; i < 4; i++) w[i] = 10'(10'h2B0 + i);
    busWrite(10'h182, 10'h009);
    for (int i = 0; i < 4; i++) busWrite(10'(10'h184 + i), w[i]);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h106);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h000);
    memM[1][9] = w;
    ramReadChk("R8 priority winner written", 1, 10'h009);
    ramReadChk("R8 priority loser untouched", 2, 10'h009);

    // R10 start landing on completion clock of a slow access
    for (int i = 0; i < 4; i++) w[i] = 10'(10'h1A0 + i);
    busWrite(10'h182, 10'h00B);
    for (int i = 0; i < 4; i++) busWrite(10'(10'h184 + i), w[i]);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h108);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h102);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h000);
    memM[3][11] = w;
    ramReadChk("R10 slow write completed", 3, 10'h00B);
    ramReadChk("R10 start while pending dropped", 1, 10'h00B);

    // R9 slow bank latency
    for (int i = 0; i < 4; i++) w[i] = ~rdM[i];
    ramWrite(3, 10'h004, w);
    busWrite(10'h182, 10'h004);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h180);
    rdChk("R9 slow result not yet valid", 10'h184, rdM[0]);
    repeat (8) @(negedge clk);
    rdM = w;
    rdChk("R9 slow result after window", 10'h184, w[0]);
    rdChk("R9 slow result word 3", 10'h187, w[3]);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h000);

    // R9 fast bank latency
    for (int i = 0; i < 4; i++) w[i] = ~rdM[i];
    ramWrite(1, 10'h00E, w);
    busWrite(10'h182, 10'h00E);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h120);
    rdChk("R9 fast result ready next clock", 10'h184, w[0]);
    busWrite(10'h183, 10'h100);
    busWrite(10'h183, 10'h000);

    // R7 reset in mid run
    busWrite(10'h180, 10'h0F0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    clearModels();
    @(negedge clk);
    chk("R7 loopAddr after reset", loopAddr, 10'd0);
    rdChk("R7 channel cleared", chanAddr(5, 2, 6), 10'd0);
    rdChk("R7 result words cleared", 10'h184, 10'd0);
    ramReadChk("R7 bank cleared", 3, 10'h004);

    finishRun();
  end
endmodule